// File: doc/BRIEF.md
# Fused Add-Multiply Unit

This block is a purely combinational datapath. It computes Z = X·(A+B) for three signed two's-complement operands of N bits and returns a signed result of 2N+2 bits. The sum A+B is never formed by a carry-propagating adder. Instead, each pair of operand bits is recoded straight into one radix-4 Booth digit in the range [−2, 2]. Every digit is built only from its own two bit positions and from two carry bits supplied by the pair below it. Because those two carries are themselves local, no carry runs across the width of the operands.

Each digit selects 0, ±X or ±2X as a partial-product row. A negative digit inverts the selected multiple and places a +1 in the row's lowest position. Sign extension is replaced by inverting each row's top bit and adding one precomputed constant row. The K digit rows, the spare +1 bit of the top digit and the constant row go into a carry-save tree of 4:2 and 3:2 compressors until two rows remain. A Brent-Kung parallel-prefix adder then adds those two rows, and it is the only carry-propagating adder in the path.

A typical use is a filter or transform stage that needs a coefficient multiplied by a pre-added pair of samples within a single cycle.

Top module: `fused_add_mul`

## Requirements
- R1: For every signed X, A and B of N bits, z_out read as a signed 2N+2-bit number equals X·(A+B) exactly.
- R2: The most negative operands are exact: X = A = B = −2^(N−1) gives +2^(2N−1), and X = −2^(N−1) is exact with any A and B.
- R3: A+B is recoded into K = floor((N+2)/2) digits, each in [−2, 2], whose sum weighted by 4^j equals A+B. Each digit uses only its own bit pair and carries from the pair directly below it. At the ports, X = 1 gives z_out = A+B.
- R4: X = 0 gives z_out = 0 for every A and B.
- R5: A negative digit is applied as the bitwise inverse of the selected multiple plus a 1 at that row's least significant position. At the ports, X = −1 gives z_out = −(A+B).
- R6: The compressor tree turns its K+2 input rows into two rows whose sum, taken modulo 2^(2N+2), equals the sum of the input rows.
- R7: The prefix adder's result equals the sum of the two tree rows, including carries that travel the full result width. Examples: z_out = −1 for X = 1, A = −1, B = 0, and z_out = 2^N for X = −1, A = B = −2^(N−1).
- R8: Swapping A and B leaves z_out unchanged.
- R9: Odd N is supported with the same exactness as even N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | N | Signed multiplicand X |
| a_in | input | N | Signed first addend A |
| b_in | input | N | Signed second addend B |
| z_out | output | 2N+2 | Signed result X·(A+B) |

## Verification
The bench builds the unit three times. N = 6 is swept over every combination of X, A and B. This reaches every digit pattern, including the "negative zero" digit, the top-pair carry cases and all sign combinations. N = 5 is also swept exhaustively; here the extended sum width is exactly N+1, which leaves the top recoding cell with the least sign headroom. N = 16 gets directed extremes and random vectors, so the tree runs with more levels (11 rows down to 2) and the prefix adder spans a width that is not a power of two.

// File: rtl/fused_add_mul.sv
module fused_add_mul #(
  parameter int N = 16
) (
  input  logic signed [N-1:0]   x_in,
  input  logic signed [N-1:0]   a_in,
  input  logic signed [N-1:0]   b_in,
  output logic signed [2*N+1:0] z_out
);
  localparam int W  = 2*N + 2;
  localparam int K  = (N + 2) / 2;
  localparam int L  = 2*K;
  localparam int NR = K + 2;
  localparam int NA = NR + 3;
  localparam int LG = $clog2(W);

  function automatic logic [W-1:0] fold_const();
    logic [W-1:0] acc;
    acc = '0;
    for (int j = 0; j < K; j++) acc = acc - (W'(1) << (N + 2*j));
    return acc;
  endfunction
  localparam logic [W-1:0] SIGN_FOLD = fold_const();

  // operands widened to a whole number of bit pairs
  logic [L-1:0] a_w, b_w;
  assign a_w = {{(L-N){a_in[N-1]}}, a_in};
  assign b_w = {{(L-N){b_in[N-1]}}, b_in};

  // digit j = -2*d_hi + d_lo + d_in
  logic [K-1:0] d_hi, d_lo, d_in;
  logic [K-1:0] cy_fa, cy_dg;
  assign cy_fa[0] = 1'b0;
  assign cy_dg[0] = 1'b0;

  for (genvar j = 0; j < K; j++) begin : g_rec
    logic ea, eb, oa, ob, k_mid, h_x;
    assign ea = a_w[2*j];
    assign eb = b_w[2*j];
    assign oa = a_w[2*j+1];
    assign ob = b_w[2*j+1];
    assign d_lo[j] = ea ^ eb ^ cy_fa[j];
    assign k_mid   = (ea & eb) | (cy_fa[j] & (ea ^ eb));
    assign h_x     = oa ^ ob;
    assign d_hi[j] = k_mid ^ h_x;
    assign d_in[j] = cy_dg[j];
    if (j < K-1) begin : g_up
      assign cy_fa[j+1] = oa | ob;
      assign cy_dg[j+1] = k_mid & ~h_x;
    end
  end

  // partial-product rows
  logic [N:0]   pp [K];
  logic [W-1:0] rows [NR];

  for (genvar j = 0; j < K; j++) begin : g_pp
    logic sel1, sel2;
    logic [N:0] mag;
    assign sel1 = d_lo[j] ^ d_in[j];
    assign sel2 = d_hi[j] ? (~d_lo[j] & ~d_in[j]) : (d_lo[j] & d_in[j]);
    assign mag  = sel1 ? {x_in[N-1], x_in} : (sel2 ? {x_in, 1'b0} : '0);
    assign pp[j] = mag ^ {(N+1){d_hi[j]}};
    if (j == 0) begin : g_first
      assign rows[j] = W'({~pp[j][N], pp[j][N-1:0]});
    end else begin : g_rest
      assign rows[j] = (W'({~pp[j][N], pp[j][N-1:0]}) << (2*j))
                     | (W'(d_hi[j-1]) << (2*j-2));
    end
  end
  assign rows[K]   = W'(d_hi[K-1]) << (2*K-2);
  assign rows[K+1] = SIGN_FOLD;

  // carry-save reduction
  function automatic void csa3(input logic [W-1:0] p, input logic [W-1:0] q,
                               input logic [W-1:0] r,
                               output logic [W-1:0] s, output logic [W-1:0] c);
    s = p ^ q ^ r;
    c = ((p & q) | (p & r) | (q & r)) << 1;
  endfunction

  logic [W-1:0] row_s, row_c;
  always_comb begin
    logic [W-1:0] cur [NA];
    logic [W-1:0] nxt [NA];
    logic [W-1:0] s1, c1, s2, c2;
    int n, m;
    for (int i = 0; i < NA; i++) cur[i] = (i < NR) ? rows[i] : '0;
    n = NR;
    for (int lv = 0; lv < NR; lv++) begin
      if (n > 2) begin
        for (int i = 0; i < NA; i++) nxt[i] = '0;
        m = 0;
        for (int g = 0; g < (NR + 3) / 4; g++) begin
          if (4*g + 3 < n) begin
            csa3(cur[4*g], cur[4*g+1], cur[4*g+2], s1, c1);
            csa3(s1, c1, cur[4*g+3], s2, c2);
            nxt[m] = s2; nxt[m+1] = c2; m = m + 2;
          end else if (4*g + 2 < n) begin
            csa3(cur[4*g], cur[4*g+1], cur[4*g+2], s1, c1);
            nxt[m] = s1; nxt[m+1] = c1; m = m + 2;
          end else if (4*g + 1 < n) begin
            nxt[m] = cur[4*g]; nxt[m+1] = cur[4*g+1]; m = m + 2;
          end else if (4*g < n) begin
            nxt[m] = cur[4*g]; m = m + 1;
          end
        end
        for (int i = 0; i < NA; i++) cur[i] = nxt[i];
        n = m;
      end
    end
    row_s = cur[0];
    row_c = cur[1];
  end

  // Brent-Kung final adder
  logic [W-1:0] z_sum;
  always_comb begin
    logic [W-1:0] gv, pv, p0;
    int d;
    p0 = row_s ^ row_c;
    gv = row_s & row_c;
    pv = p0;
    for (int l = 0; l < LG; l++) begin
      d = 1 << l;
      for (int i = 0; i < W; i++) begin
        if ((i % (2*d)) == (2*d - 1)) begin
          gv[i] = gv[i] | (pv[i] & gv[i-d]);
          pv[i] = pv[i] & pv[i-d];
        end
      end
    end
    for (int l = LG - 2; l >= 0; l--) begin
      d = 1 << l;
      for (int i = 0; i < W; i++) begin
        if (i >= 3*d - 1 && ((i + 1) % (2*d)) == d) begin
          gv[i] = gv[i] | (pv[i] & gv[i-d]);
          pv[i] = pv[i] & pv[i-d];
        end
      end
    end
    z_sum = p0 ^ {gv[W-2:0], 1'b0};
  end

  assign z_out = $signed(z_sum);

  // R3
  always_comb begin : chk_digits
    logic [W-1:0] acc, want;
    int dv;
    acc = '0;
    for (int j = 0; j < K; j++) begin
      dv  = -2*int'(d_hi[j]) + int'(d_lo[j]) + int'(d_in[j]);
      acc = acc + (W'(dv) << (2*j));
    end
    want = W'(a_in) + W'(b_in);
    booth_sum_chk: assert (acc == want)
      else $error("digit sum %0h differs from A+B %0h", acc, want);
  end

  // R6
  always_comb begin : chk_tree
    logic [W-1:0] tot;
    tot = '0;
    for (int i = 0; i < NR; i++) tot = tot + rows[i];
    tree_sum_chk: assert (W'(row_s + row_c) == tot)
      else $error("tree rows lose value: %0h vs %0h", row_s + row_c, tot);
  end

  // R7
  always_comb begin : chk_prefix
    prefix_add_chk: assert (z_sum == W'(row_s + row_c))
      else $error("prefix sum %0h vs %0h", z_sum, row_s + row_c);
  end

  // R1
  always_comb begin : chk_product
    logic [W-1:0] xe, se;
    xe = W'(x_in);
    se = W'(a_in) + W'(b_in);
    product_chk: assert (z_sum == W'(xe * se))
      else $error("product %0h vs %0h", z_sum, xe * se);
  end
endmodule

// File: tb/fused_add_mul_tb.sv
module fused_add_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int NRAND      = 4000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic signed [15:0] x16 = '0, a16 = '0, b16 = '0;
  logic signed [33:0] z16;
  logic signed [5:0]  x6 = '0, a6 = '0, b6 = '0;
  logic signed [13:0] z6;
  logic signed [4:0]  x5 = '0, a5 = '0, b5 = '0;
  logic signed [11:0] z5;

  fused_add_mul #(.N(16)) u_dut  (.x_in(x16), .a_in(a16), .b_in(b16), .z_out(z16));
  fused_add_mul #(.N(6))  u_dut6 (.x_in(x6),  .a_in(a6),  .b_in(b6),  .z_out(z6));
  fused_add_mul #(.N(5))  u_dut5 (.x_in(x5),  .a_in(a5),  .b_in(b5),  .z_out(z5));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run16(input string tag, input int xv, input int av, input int bv);
    x16 = 16'(xv); a16 = 16'(av); b16 = 16'(bv);
    #1;
    chk(tag, longint'(z16),
        longint'(x16) * (longint'(a16) + longint'(b16)));
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    #3;
    // R1 idle operands
    chk("R1", longint'(z16), 0);

    // R2 extremes at N=16
    run16("R2", -32768, -32768, -32768);
    run16("R2", -32768, 32767, 32767);
    run16("R2", 32767, -32768, -32768);
    // R7 full-width carries
    run16("R7", 1, -1, 0);
    run16("R7", -1, -32768, -32768);
    run16("R7", 1, 32767, 32767);
    // R4 / R5 / R3 at N=16
    run16("R4", 0, -32768, 12345);
    run16("R5", -1, 32767, 1);
    run16("R3", 1, -32768, -1);

    // R6 / R8 random at N=16
    void'($urandom(11));
    for (int i = 0; i < NRAND; i++) begin
      int xv, av, bv;
      longint z_ab;
      xv = int'($urandom()); av = int'($urandom()); bv = int'($urandom());
      run16("R6", xv, av, bv);
      z_ab = longint'(z16);
      x16 = 16'(xv); a16 = 16'(bv); b16 = 16'(av);
      #1;
      chk("R8", longint'(z16), z_ab);
      #1;
    end

    // exhaustive N=6
    for (int xi = -32; xi < 32; xi++) begin
      for (int ai = -32; ai < 32; ai++) begin
        for (int bi = -32; bi < 32; bi++) begin
          x6 = 6'(xi); a6 = 6'(ai); b6 = 6'(bi);
          #1;
          if (xi == 0)                              tag = "R4";
          else if (xi == -1)                        tag = "R5";
          else if (xi == 1)                         tag = "R3";
          else if (xi == -32 || (ai == -32 && bi == -32)) tag = "R2";
          else                                      tag = "R1";
          chk(tag, longint'(z6), longint'(xi) * longint'(ai + bi));
          #1;
        end
      end
    end

    // exhaustive N=5 (odd width)
    for (int xi = -16; xi < 16; xi++) begin
      for (int ai = -16; ai < 16; ai++) begin
        for (int bi = -16; bi < 16; bi++) begin
          x5 = 5'(xi); a5 = 5'(ai); b5 = 5'(bi);
          #1;
          chk("R9", longint'(z5), longint'(xi) * longint'(ai + bi));
          #1;
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule